// File: doc/BRIEF.md
# Byte-Wide Handshake Register Bus Slave

This block is the device-side end of an asynchronous, byte-wide, bidirectional link to a host microcontroller. The host frames a request by raising a start line. It then pushes six bytes over the shared byte bus: a command, a register number and a 32-bit data word, least significant byte first. Each byte moves with a two-wire four-phase handshake. The host raises its handshake wire, the slave takes the byte and raises its own wire, the host drops its wire, and the slave drops its wire.

Once the request is complete, the slave makes one access on a simple register-file port (address, write data, write strobe, combinational read data). It then returns a reply word to the host, again least significant byte first, with the same handshake. The host first flips the read/write line so that the slave drives the bus. A build-time option appends a 32-bit status word, which turns the four reply bytes into eight.

After the last reply byte, the slave raises an acknowledge and holds it until the host drops start. A separate host reset line aborts any transaction in flight. The start, handshake and host reset inputs are asynchronous and each passes through a synchronizer before use.

Top module: `hsbus_slave`

## Requirements
- R1: After system reset, hs_slave_out, ack_out and bus_oe are all 0 and rf_we stays 0.
- R2: For every byte, hs_slave_out rises within 4 clock cycles after hs_host_in rises, and falls within 4 cycles after hs_host_in falls.
- R3: Request bytes are taken in this order: command, register number, then data bytes 0 to 3, where byte k is data bits [8k+7:8k].
- R4: Command 8'h01 (write) produces exactly one single-cycle rf_we pulse, with rf_addr equal to the register number and rf_wdata equal to the data word.
- R5: Command 8'h00 (read) returns the rf_rdata value at the register number as the reply word, with no rf_we pulse.
- R6: A write returns its own data word as the reply. Any command other than 8'h00 or 8'h01 produces no rf_we pulse, leaves the register file unchanged and returns a reply word of 0.
- R7: Reply bytes are driven least significant byte first, byte k being reply bits [8k+7:8k]. bus_oe is 1 while a reply byte is handshaken with rw_in at 0 (read), and 0 while request bytes are taken with rw_in at 1.
- R8: ack_out is 1 once the final reply byte's handshake completes. It stays 1 while start_in is held high and returns to 0 within 4 cycles after start_in falls.
- R9: Raising host_rst_in at any point drives hs_slave_out, ack_out and bus_oe to 0 within 4 cycles. The next transaction is then received from its command byte.
- R10: With STATUS_EN set, the reply is eight bytes. Bytes 4 to 7 carry the status word {16'h0000, register number, command}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset |
| host_rst_in | input | 1 | Asynchronous abort line from the host, active high |
| start_in | input | 1 | Asynchronous transaction framing line from the host |
| rw_in | input | 1 | Bus direction from the host: 1 host drives, 0 slave drives |
| hs_host_in | input | 1 | Asynchronous host handshake wire |
| bus_in | input | 8 | Byte bus as seen at the pins |
| bus_out | output | 8 | Byte the slave drives onto the bus |
| bus_oe | output | 1 | Output enable for bus_out |
| hs_slave_out | output | 1 | Slave handshake wire |
| ack_out | output | 1 | Transaction complete indication |
| rf_addr | output | 8 | Register file address |
| rf_wdata | output | 32 | Register file write data |
| rf_we | output | 1 | Register file write strobe, one cycle |
| rf_rdata | input | 32 | Register file read data for rf_addr |

## Verification
A controller stuck in a wrong phase shows at the pins as a slave handshake that never answers the host. The next host edge waits more than four cycles, so a lost or extra byte count surfaces on the very next byte. A misplaced byte slot or a wrong reply latch shows up as a wrong register-file write or wrong reply bytes at the end of that same transaction. An output enable or acknowledge asserted in the wrong phase is visible within one cycle of entering that phase.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_READ  = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_HI,
    ST_RX_LO,
    ST_EXEC,
    ST_TX_HI,
    ST_TX_LO,
    ST_ACK
  } hs_state_e;

endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
        end else begin
          chain <= {chain[STAGES-2:0], async_in[g]};
        end
      end
      assign sync_out[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/hsbus_ctrl.sv
module hsbus_ctrl
  import hsbus_pkg::*;
#(
  parameter int RX_BYTES = 6,
  parameter int TX_BYTES = 4,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_s,
  input  logic             start_s,
  input  logic             hs_s,
  output hs_state_e        state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hs_slave_o,
  output logic             ack_o,
  output logic             rx_take_o,
  output logic             exec_o,
  output logic             tx_phase_o,
  output logic             tx_last_o
);

  localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(RX_BYTES - 1);
  localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(TX_BYTES - 1);

  hs_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             hs_q;
  logic             ack_q;
  logic             rx_last;

  assign rx_last = (state == ST_RX_LO) && !hs_s && (cnt == RX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      hs_q  <= 1'b0;
      ack_q <= 1'b0;
    end else if (abort_s) begin
      state <= ST_IDLE;
      cnt   <= '0;
      hs_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start_s) state <= ST_RX_HI;
        end
        ST_RX_HI: begin
          if (hs_s) begin
            hs_q  <= 1'b1;
            state <= ST_RX_LO;
          end
        end
        ST_RX_LO: begin
          if (!hs_s) begin
            hs_q <= 1'b0;
            if (rx_last) begin
              cnt   <= '0;
              state <= ST_EXEC;
            end else begin
              cnt   <= cnt + 1'b1;
              state <= ST_RX_HI;
            end
          end
        end
        ST_EXEC: begin
          state <= ST_TX_HI;
        end
        ST_TX_HI: begin
          if (hs_s) begin
            hs_q  <= 1'b1;
            state <= ST_TX_LO;
          end
        end
        ST_TX_LO: begin
          if (!hs_s) begin
            hs_q <= 1'b0;
            if (cnt == TX_LAST) begin
              ack_q <= 1'b1;
              state <= ST_ACK;
            end else begin
              cnt   <= cnt + 1'b1;
              state <= ST_TX_HI;
            end
          end
        end
        ST_ACK: begin
          if (!start_s) begin
            ack_q <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state;
  assign cnt_o      = cnt;
  assign hs_slave_o = hs_q;
  assign ack_o      = ack_q;
  assign rx_take_o  = (state == ST_RX_HI) && hs_s;
  assign exec_o     = (state == ST_EXEC);
  assign tx_phase_o = (state == ST_TX_HI) || (state == ST_TX_LO);
  assign tx_last_o  = (state == ST_TX_LO) && !hs_s && (cnt == TX_LAST);

endmodule

// File: rtl/hsbus_frame.sv
module hsbus_frame
  import hsbus_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter bit STATUS_EN  = 1'b0,
  parameter int TX_BYTES   = 4,
  parameter int CNT_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BYTE_W-1:0]       bus_in,
  input  logic                    take,
  input  logic [CNT_W-1:0]        cnt,
  input  logic                    exec,
  input  logic                    tx_phase,
  input  logic [WORD_BYTES*8-1:0] rf_rdata,
  output logic [BYTE_W-1:0]       rf_addr,
  output logic [WORD_BYTES*8-1:0] rf_wdata,
  output logic                    rf_we,
  output logic [BYTE_W-1:0]       bus_out
);

  localparam int WORD_W  = WORD_BYTES * BYTE_W;
  localparam int REPLY_W = TX_BYTES * BYTE_W;

  logic [BYTE_W-1:0]  cmd_q;
  logic [BYTE_W-1:0]  reg_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [REPLY_W-1:0] reply_q;
  logic [REPLY_W-1:0] reply_next;

  function automatic logic [WORD_W-1:0] pick_reply(
    input logic [BYTE_W-1:0] cmd,
    input logic [WORD_W-1:0] rd,
    input logic [WORD_W-1:0] wd
  );
    case (cmd)
      CMD_READ:  return rd;
      CMD_WRITE: return wd;
      default:   return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] make_status(
    input logic [BYTE_W-1:0] cmd,
    input logic [BYTE_W-1:0] regno
  );
    return WORD_W'({regno, cmd});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else if (take) begin
      if (cnt == CNT_W'(0)) cmd_q <= bus_in;
      if (cnt == CNT_W'(1)) reg_q <= bus_in;
      for (int i = 0; i < WORD_BYTES; i++) begin
        if (cnt == CNT_W'(i + 2)) wdata_q[8*i +: 8] <= bus_in;
      end
    end
  end

  generate
    if (STATUS_EN) begin : g_status
      assign reply_next = {make_status(cmd_q, reg_q), pick_reply(cmd_q, rf_rdata, wdata_q)};
    end else begin : g_plain
      assign reply_next = pick_reply(cmd_q, rf_rdata, wdata_q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply_q <= '0;
    end else if (exec) begin
      reply_q <= reply_next;
    end
  end

  always_comb begin
    bus_out = '0;
    if (tx_phase) begin
      for (int i = 0; i < TX_BYTES; i++) begin
        if (cnt == CNT_W'(i)) bus_out = reply_q[8*i +: 8];
      end
    end
  end

  assign rf_addr  = reg_q;
  assign rf_wdata = wdata_q;
  assign rf_we    = exec && (cmd_q == CMD_WRITE);

endmodule

// File: rtl/hsbus_slave.sv
module hsbus_slave
  import hsbus_pkg::*;
#(
  parameter int WORD_BYTES  = 4,
  parameter bit STATUS_EN   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_rst_in,
  input  logic                    start_in,
  input  logic                    rw_in,
  input  logic                    hs_host_in,
  input  logic [7:0]              bus_in,
  output logic [7:0]              bus_out,
  output logic                    bus_oe,
  output logic                    hs_slave_out,
  output logic                    ack_out,
  output logic [7:0]              rf_addr,
  output logic [WORD_BYTES*8-1:0] rf_wdata,
  output logic                    rf_we,
  input  logic [WORD_BYTES*8-1:0] rf_rdata
);

  localparam int RX_BYTES = 2 + WORD_BYTES;
  localparam int TX_BYTES = STATUS_EN ? 2 * WORD_BYTES : WORD_BYTES;
  localparam int MAX_B    = (RX_BYTES > TX_BYTES) ? RX_BYTES : TX_BYTES;
  localparam int CNT_W    = $clog2(MAX_B);

  logic [2:0]       sync_vec;
  logic             abort_s;
  logic             start_s;
  logic             hs_s;
  logic             rw_q;
  hs_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             rx_take;
  logic             exec;
  logic             tx_phase;
  logic             tx_last;

  hsbus_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({host_rst_in, hs_host_in, start_in}),
    .sync_out (sync_vec)
  );

  assign abort_s = sync_vec[2];
  assign hs_s    = sync_vec[1];
  assign start_s = sync_vec[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rw_q <= 1'b1;
    else        rw_q <= rw_in;
  end

  hsbus_ctrl #(.RX_BYTES(RX_BYTES), .TX_BYTES(TX_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_s    (abort_s),
    .start_s    (start_s),
    .hs_s       (hs_s),
    .state_o    (state),
    .cnt_o      (cnt),
    .hs_slave_o (hs_slave_out),
    .ack_o      (ack_out),
    .rx_take_o  (rx_take),
    .exec_o     (exec),
    .tx_phase_o (tx_phase),
    .tx_last_o  (tx_last)
  );

  hsbus_frame #(
    .WORD_BYTES (WORD_BYTES),
    .STATUS_EN  (STATUS_EN),
    .TX_BYTES   (TX_BYTES),
    .CNT_W      (CNT_W)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_in   (bus_in),
    .take     (rx_take),
    .cnt      (cnt),
    .exec     (exec),
    .tx_phase (tx_phase),
    .rf_rdata (rf_rdata),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata),
    .rf_we    (rf_we),
    .bus_out  (bus_out)
  );

  assign bus_oe = tx_phase && !rw_q;

endmodule

// File: rtl/hsbus_slave_chk.sv
module hsbus_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       abort_s,
  input logic       hs_s,
  input logic       hs_slave,
  input logic       ack,
  input logic       bus_oe,
  input logic [7:0] bus_out,
  input logic       tx_phase,
  input logic       tx_last,
  input logic       rf_we
);

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_s |=> (!hs_slave && !ack && !bus_oe));

  // R2
  hs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_slave) |-> hs_s);

  // R2
  hs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_slave) |-> (!hs_s || $past(abort_s)));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_slave && tx_phase && $past(hs_slave && tx_phase)) |-> $stable(bus_out));

  // R8
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(tx_last));

  // R8
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!hs_slave && !bus_oe));

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

endmodule

bind hsbus_slave hsbus_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .abort_s  (abort_s),
  .hs_s     (hs_s),
  .hs_slave (hs_slave_out),
  .ack      (ack_out),
  .bus_oe   (bus_oe),
  .bus_out  (bus_out),
  .tx_phase (tx_phase),
  .tx_last  (tx_last),
  .rf_we    (rf_we)
);

// File: tb/hsbus_slave_bench.sv
module hsbus_slave_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [1:0]      start_i, rw_i, hs_i, hrst_i;
  logic [1:0][7:0] bin_i;
  logic [1:0][7:0] bout_o;
  logic [1:0]      oe_o, ack_o, hss_o, we_o;
  logic [1:0][7:0] addr_o;
  logic [1:0][31:0] wdata_o, rdata_i;
  logic [31:0]     mem0 [256];
  logic [31:0]     mem1 [256];
  int              we_cnt0 = 0;
  int              we_cnt1 = 0;
  int              checks = 0;
  int              errors = 0;

  assign rdata_i[0] = mem0[addr_o[0]];
  assign rdata_i[1] = mem1[addr_o[1]];

  always @(posedge clk) begin
    if (we_o[0]) begin mem0[addr_o[0]] <= wdata_o[0]; we_cnt0++; end
    if (we_o[1]) begin mem1[addr_o[1]] <= wdata_o[1]; we_cnt1++; end
  end

  hsbus_slave #(.STATUS_EN(1'b0)) u_hsbus_slave (
    .clk(clk), .rst_n(rst_n), .host_rst_in(hrst_i[0]), .start_in(start_i[0]),
    .rw_in(rw_i[0]), .hs_host_in(hs_i[0]), .bus_in(bin_i[0]), .bus_out(bout_o[0]),
    .bus_oe(oe_o[0]), .hs_slave_out(hss_o[0]), .ack_out(ack_o[0]), .rf_addr(addr_o[0]),
    .rf_wdata(wdata_o[0]), .rf_we(we_o[0]), .rf_rdata(rdata_i[0]));

  hsbus_slave #(.STATUS_EN(1'b1)) u_hsbus_slave_st (
    .clk(clk), .rst_n(rst_n), .host_rst_in(hrst_i[1]), .start_in(start_i[1]),
    .rw_in(rw_i[1]), .hs_host_in(hs_i[1]), .bus_in(bin_i[1]), .bus_out(bout_o[1]),
    .bus_oe(oe_o[1]), .hs_slave_out(hss_o[1]), .ack_out(ack_o[1]), .rf_addr(addr_o[1]),
    .rf_wdata(wdata_o[1]), .rf_we(we_o[1]), .rf_rdata(rdata_i[1]));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int wcount(input int d);
    return (d == 0) ? we_cnt0 : we_cnt1;
  endfunction

  task automatic wait_hss(input int d, input logic lvl, input string tag);
    int n = 0;
    while (hss_o[d] !== lvl && n < 5) begin @(negedge clk); n++; end
    check(hss_o[d] === lvl, tag, 64'(hss_o[d]), 64'(lvl));
  endtask

  task automatic wait_ack(input int d, input logic lvl, input string tag);
    int n = 0;
    while (ack_o[d] !== lvl && n < 5) begin @(negedge clk); n++; end
    check(ack_o[d] === lvl, tag, 64'(ack_o[d]), 64'(lvl));
  endtask

  task automatic send_byte(input int d, input logic [7:0] b);
    @(negedge clk);
    bin_i[d] = b;
    hs_i[d]  = 1'b1;
    wait_hss(d, 1'b1, "R2 slave handshake rise on request byte");
    check(oe_o[d] == 1'b0, "R7 bus released while host writes", 64'(oe_o[d]), 64'd0);
    @(negedge clk);
    hs_i[d] = 1'b0;
    wait_hss(d, 1'b0, "R2 slave handshake fall on request byte");
  endtask

  task automatic recv_byte(input int d, output logic [7:0] b);
    @(negedge clk);
    hs_i[d] = 1'b1;
    wait_hss(d, 1'b1, "R2 slave handshake rise on reply byte");
    check(oe_o[d] == 1'b1, "R7 bus driven during reply", 64'(oe_o[d]), 64'd1);
    b = bout_o[d];
    @(negedge clk);
    hs_i[d] = 1'b0;
    wait_hss(d, 1'b0, "R2 slave handshake fall on reply byte");
  endtask

  task automatic do_txn(input int d, input logic [7:0] cmd, input logic [7:0] regno,
                        input logic [31:0] data, input int nrep, input int hold,
                        output logic [63:0] reply);
    logic [7:0] b;
    reply = '0;
    @(negedge clk);
    start_i[d] = 1'b1;
    rw_i[d]    = 1'b1;
    repeat (3) @(negedge clk);
    send_byte(d, cmd);
    send_byte(d, regno);
    for (int i = 0; i < 4; i++) send_byte(d, data[8*i +: 8]);
    @(negedge clk);
    rw_i[d] = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nrep; i++) begin
      recv_byte(d, b);
      reply[8*i +: 8] = b;
    end
    check(ack_o[d] == 1'b1, "R8 ack after final reply byte", 64'(ack_o[d]), 64'd1);
    repeat (hold) @(negedge clk);
    check(ack_o[d] == 1'b1, "R8 ack held while start high", 64'(ack_o[d]), 64'd1);
    start_i[d] = 1'b0;
    rw_i[d]    = 1'b1;
    wait_ack(d, 1'b0, "R8 ack cleared after start drops");
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      check(hss_o[d] == 1'b0, "R1 handshake low after reset", 64'(hss_o[d]), 64'd0);
      check(ack_o[d] == 1'b0, "R1 ack low after reset", 64'(ack_o[d]), 64'd0);
      check(oe_o[d] == 1'b0, "R1 bus released after reset", 64'(oe_o[d]), 64'd0);
    end
    check(we_cnt0 + we_cnt1 == 0, "R1 no write strobe after reset", 64'(we_cnt0 + we_cnt1), 64'd0);
  endtask

  task automatic t_write();
    logic [63:0] rep;
    int w0 = wcount(0);
    do_txn(0, 8'h01, 8'h05, {8'hA1, 8'hB2, 8'hC3, 8'hD4}, 4, 0, rep);
    check(wcount(0) - w0 == 1, "R4 single write strobe", 64'(wcount(0) - w0), 64'd1);
    check(mem0[5] == 32'hA1B2C3D4, "R3 R4 data assembled low byte first", 64'(mem0[5]), 64'hA1B2C3D4);
    check(rep[31:0] == 32'hA1B2C3D4, "R6 write reply echoes data", rep, 64'hA1B2C3D4);
  endtask

  task automatic t_read();
    logic [63:0] rep;
    int w0 = wcount(0);
    do_txn(0, 8'h00, 8'h22, 32'h5555_5555, 4, 0, rep);
    check(rep[31:0] == 32'h1357_9BDF, "R5 read reply is register value", rep, 64'h13579BDF);
    check(rep[7:0] == 8'hDF, "R7 first reply byte is least significant", 64'(rep[7:0]), 64'hDF);
    check(wcount(0) == w0, "R5 read makes no write", 64'(wcount(0)), 64'(w0));
  endtask

  task automatic t_bad_cmd();
    logic [63:0] rep;
    int w0 = wcount(0);
    do_txn(0, 8'h07, 8'h05, 32'hDEAD_BEEF, 4, 0, rep);
    check(wcount(0) == w0, "R6 unknown command makes no write", 64'(wcount(0)), 64'(w0));
    check(rep[31:0] == 32'h0, "R6 unknown command replies zero", rep, 64'h0);
    do_txn(0, 8'h00, 8'h05, 32'h0, 4, 0, rep);
    check(rep[31:0] == 32'hA1B2C3D4, "R6 register unchanged by unknown command", rep, 64'hA1B2C3D4);
  endtask

  task automatic t_ack_hold();
    logic [63:0] rep;
    do_txn(0, 8'h00, 8'h22, 32'h0, 4, 12, rep);
    check(rep[31:0] == 32'h1357_9BDF, "R8 reply intact with long ack hold", rep, 64'h13579BDF);
  endtask

  task automatic t_abort();
    logic [63:0] rep;
    @(negedge clk);
    start_i[0] = 1'b1;
    rw_i[0]    = 1'b1;
    repeat (3) @(negedge clk);
    send_byte(0, 8'h01);
    send_byte(0, 8'h09);
    @(negedge clk);
    bin_i[0] = 8'h77;
    hs_i[0]  = 1'b1;
    wait_hss(0, 1'b1, "R2 handshake rise before abort");
    @(negedge clk);
    hrst_i[0]  = 1'b1;
    start_i[0] = 1'b0;
    hs_i[0]    = 1'b0;
    repeat (4) @(negedge clk);
    check(hss_o[0] == 1'b0, "R9 handshake low after host reset", 64'(hss_o[0]), 64'd0);
    check(ack_o[0] == 1'b0, "R9 ack low after host reset", 64'(ack_o[0]), 64'd0);
    check(oe_o[0] == 1'b0, "R9 bus released after host reset", 64'(oe_o[0]), 64'd0);
    hrst_i[0] = 1'b0;
    repeat (4) @(negedge clk);
    do_txn(0, 8'h01, 8'h09, 32'h0BAD_F00D, 4, 0, rep);
    check(mem0[9] == 32'h0BAD_F00D, "R9 clean write after abort", 64'(mem0[9]), 64'h0BADF00D);
    do_txn(0, 8'h00, 8'h09, 32'h0, 4, 0, rep);
    check(rep[31:0] == 32'h0BAD_F00D, "R9 clean read after abort", rep, 64'h0BADF00D);
  endtask

  task automatic t_status();
    logic [63:0] rep;
    do_txn(1, 8'h01, 8'h3C, 32'h0123_4567, 8, 0, rep);
    check(mem1[8'h3C] == 32'h0123_4567, "R10 write through status build", 64'(mem1[8'h3C]), 64'h01234567);
    check(rep == {16'h0, 8'h3C, 8'h01, 32'h0123_4567}, "R10 write reply with status", rep,
          {16'h0, 8'h3C, 8'h01, 32'h0123_4567});
    do_txn(1, 8'h00, 8'h3C, 32'h0, 8, 0, rep);
    check(rep == {16'h0, 8'h3C, 8'h00, 32'h0123_4567}, "R10 read reply with status", rep,
          {16'h0, 8'h3C, 8'h00, 32'h0123_4567});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem0[i] = 32'h0; mem1[i] = 32'h0; end
    mem0[8'h22] = 32'h1357_9BDF;
    rst_n   = 1'b0;
    start_i = '0;
    rw_i    = 2'b11;
    hs_i    = '0;
    hrst_i  = '0;
    bin_i   = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_read();
    t_bad_cmd();
    t_ack_hold();
    t_abort();
    t_status();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule